// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

This block sits at the tail of a single-precision two-input arithmetic unit. It runs when at least one operand is a NaN. It decides which NaN operand becomes the result, converts that operand to a quiet NaN, and raises the invalid-operation flag when either operand is a signaling NaN. A two-bit policy input selects the selection rule, so one instance can serve several floating-point conventions. A default-NaN mode input replaces the selected result with a fixed NaN pattern. The invalid flag still follows the operands in that mode.

Operands are presented together with a valid strobe. The result and the flag appear one clock later, together with an output valid. Between strobes the registered result and flag keep their values.

Top module: `nan_pick_unit`

## Requirements
- R1: An operand is a NaN when its exponent field (bits 30:23) is all ones and its mantissa (bits 22:0) is non-zero. A NaN with mantissa bit 22 set is quiet, and one with bit 22 clear is signaling. The selected operand is output with bit 22 forced to one and all other bits, sign included, unchanged.
- R2: Policy code 0 selects a if a is signaling, else b if b is signaling, else a if a is quiet, else b.
- R3: Policy codes 1 and 3 select a if a is any NaN, otherwise b.
- R4: Policy code 2 handles three cases. When exactly one operand is a NaN, that operand is selected. When one operand is signaling and the other quiet, the quiet one is selected. When both are of the same kind, the operand with the larger magnitude is selected.
- R5: For the policy-2 magnitude comparison, bits 30:0 are compared as unsigned values. When they are equal, a counts as larger exactly when the full 32-bit word of a is below that of b, which means a has sign 0 and b has sign 1.
- R6: invalid_o is 1 when either operand is a signaling NaN, under every policy, and 0 otherwise.
- R7: With dflt_mode_i set, result_o equals the DEFAULT_NAN parameter (default 32'h7FC00000). invalid_o still follows R6.
- R8: valid_o is valid_i delayed by one clock, and result_o and invalid_o belong to the operands sampled at that edge.
- R9: While valid_i is low, result_o and invalid_o keep their previous values.
- R10: After reset, valid_o, result_o and invalid_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands are valid this cycle |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| policy_i | input | 2 | Selection rule code |
| dflt_mode_i | input | 1 | Force the default NaN as the result |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Selected, quieted NaN |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
The hardest case to reach is the last step of the policy-2 tie-break. Two NaNs must have identical bits 30:0 and differ only in sign, and both must be of the same kind, so that neither the quiet-over-signaling rule nor the magnitude compare decides the outcome. The stimulus table covers this with quiet pairs that differ only in sign, placed once in each operand order. It also includes signaling pairs with distinct magnitudes, and negative signaling inputs that show the sign survives quieting.

// File: rtl/nan_pick_pkg.sv
package nan_pick_pkg;
  localparam int unsigned EXP_W = 8;
  localparam int unsigned MAN_W = 23;
  localparam int unsigned FP_W  = 1 + EXP_W + MAN_W;

  typedef enum logic [1:0] {
    POL_ORDERED   = 2'd0,
    POL_FIRST     = 2'd1,
    POL_MAGNITUDE = 2'd2,
    POL_FIRST_ALT = 2'd3
  } policy_e;

  typedef struct packed {
    logic is_nan;
    logic is_quiet;
    logic is_sig;
  } nan_class_t;
endpackage

// File: rtl/nan_class.sv
module nan_class #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned W    = 1 + EXP_W + MAN_W
) (
  input  logic                   [W-1:0] val_i,
  output nan_pick_pkg::nan_class_t       cls_o
);
  logic exp_ones, man_nz;
  assign exp_ones = &val_i[W-2:MAN_W];
  assign man_nz   = |val_i[MAN_W-1:0];

  always_comb begin
    cls_o.is_nan   = exp_ones & man_nz;
    cls_o.is_quiet = exp_ones & val_i[MAN_W-1];
    cls_o.is_sig   = exp_ones & man_nz & ~val_i[MAN_W-1];
  end
endmodule

// File: rtl/nan_choose.sv
module nan_choose #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]             a_i,
  input  logic [W-1:0]             b_i,
  input  nan_pick_pkg::nan_class_t a_cls_i,
  input  nan_pick_pkg::nan_class_t b_cls_i,
  input  nan_pick_pkg::policy_e    policy_i,
  output logic                     pick_b_o
);
  import nan_pick_pkg::*;

  logic [W-2:0] a_mag, b_mag;
  logic         a_larger;

  assign a_mag = a_i[W-2:0];
  assign b_mag = b_i[W-2:0];

  // magnitude first, then positive sign wins a tie
  always_comb begin
    if (a_mag != b_mag) a_larger = (a_mag > b_mag);
    else                a_larger = (a_i < b_i);
  end

  always_comb begin
    unique case (policy_i)
      POL_ORDERED: begin
        if      (a_cls_i.is_sig)   pick_b_o = 1'b0;
        else if (b_cls_i.is_sig)   pick_b_o = 1'b1;
        else if (a_cls_i.is_quiet) pick_b_o = 1'b0;
        else                       pick_b_o = 1'b1;
      end
      POL_MAGNITUDE: begin
        if (a_cls_i.is_sig) begin
          if      (b_cls_i.is_sig)   pick_b_o = ~a_larger;
          else if (b_cls_i.is_quiet) pick_b_o = 1'b1;
          else                       pick_b_o = 1'b0;
        end else if (a_cls_i.is_quiet) begin
          if (b_cls_i.is_sig || !b_cls_i.is_nan) pick_b_o = 1'b0;
          else                                   pick_b_o = ~a_larger;
        end else begin
          pick_b_o = 1'b1;
        end
      end
      default: pick_b_o = ~a_cls_i.is_nan;
    endcase
  end
endmodule

// File: rtl/nan_pick_unit.sv
module nan_pick_unit #(
  parameter int unsigned EXP_W       = 8,
  parameter int unsigned MAN_W       = 23,
  parameter logic [31:0] DEFAULT_NAN = 32'h7FC0_0000,
  localparam int unsigned W          = 1 + EXP_W + MAN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   policy_i,
  input  logic         dflt_mode_i,
  output logic         valid_o,
  output logic [W-1:0] result_o,
  output logic         invalid_o
);
  import nan_pick_pkg::*;

  logic [1:0][W-1:0] opnd;
  nan_class_t [1:0]  cls;
  logic              pick_b;
  logic [W-1:0]      chosen, quieted, res_d;
  logic              inv_d;

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    nan_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_cls (
      .val_i (opnd[g]),
      .cls_o (cls[g])
    );
  end

  nan_choose #(.W(W)) i_choose (
    .a_i      (a_i),
    .b_i      (b_i),
    .a_cls_i  (cls[0]),
    .b_cls_i  (cls[1]),
    .policy_i (policy_e'(policy_i)),
    .pick_b_o (pick_b)
  );

  always_comb begin
    chosen             = pick_b ? b_i : a_i;
    quieted            = chosen;
    quieted[MAN_W-1]   = 1'b1;
    res_d              = dflt_mode_i ? DEFAULT_NAN[W-1:0] : quieted;
    inv_d              = cls[0].is_sig | cls[1].is_sig;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_d;
        invalid_o <= inv_d;
      end
    end
  end
endmodule

// File: rtl/nan_pick_unit_chk.sv
module nan_pick_unit_chk #(
  parameter int unsigned EXP_W       = 8,
  parameter int unsigned MAN_W       = 23,
  parameter logic [31:0] DEFAULT_NAN = 32'h7FC0_0000,
  localparam int unsigned W          = 1 + EXP_W + MAN_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         dflt_mode_i,
  input logic         valid_o,
  input logic [W-1:0] result_o,
  input logic         invalid_o
);
  logic a_sig, b_sig, any_nan;
  assign a_sig   = (&a_i[W-2:MAN_W]) & (|a_i[MAN_W-2:0]) & ~a_i[MAN_W-1];
  assign b_sig   = (&b_i[W-2:MAN_W]) & (|b_i[MAN_W-2:0]) & ~b_i[MAN_W-1];
  assign any_nan = ((&a_i[W-2:MAN_W]) & (|a_i[MAN_W-1:0])) |
                   ((&b_i[W-2:MAN_W]) & (|b_i[MAN_W-1:0]));

  assert_valid_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(invalid_o)));
  assert_invalid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (invalid_o == $past(a_sig | b_sig)));
  assert_dflt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dflt_mode_i) |=> (result_o == DEFAULT_NAN[W-1:0]));
  assert_quiet_out_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && any_nan && !dflt_mode_i) |=>
      ((&result_o[W-2:MAN_W]) && result_o[MAN_W-1]));
endmodule

bind nan_pick_unit nan_pick_unit_chk #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .DEFAULT_NAN(DEFAULT_NAN)
) i_nan_pick_unit_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .a_i         (a_i),
  .b_i         (b_i),
  .dflt_mode_i (dflt_mode_i),
  .valid_o     (valid_o),
  .result_o    (result_o),
  .invalid_o   (invalid_o)
);

// File: tb/test_nan_pick_unit.sv
module test_nan_pick_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC       = 19;
  localparam int  WDOG       = 5000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [1:0]  policy_i = '0;
  logic        dflt_mode_i = 1'b0;
  logic        valid_o;
  logic [31:0] result_o;
  logic        invalid_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nan_pick_unit i_nan_pick_unit (
    .clk_i, .rst_ni, .valid_i, .a_i, .b_i, .policy_i, .dflt_mode_i,
    .valid_o, .result_o, .invalid_o
  );

  // {a, b, policy, dflt, expected result, expected invalid}
  localparam logic [99:0] VEC [NVEC] = '{
    {32'h7F800005, 32'h7F800003, 2'd0, 1'b0, 32'h7FC00005, 1'b1}, // R2 a sig
    {32'h7FC00001, 32'h7F800003, 2'd0, 1'b0, 32'h7FC00003, 1'b1}, // R2 b sig
    {32'h7FC00001, 32'hFFC00002, 2'd0, 1'b0, 32'h7FC00001, 1'b0}, // R2 a quiet
    {32'h3F800000, 32'hFFC00002, 2'd0, 1'b0, 32'hFFC00002, 1'b0}, // R2 b only
    {32'h7FC00001, 32'h7F800003, 2'd1, 1'b0, 32'h7FC00001, 1'b1}, // R3
    {32'h3F800000, 32'h7F800003, 2'd1, 1'b0, 32'h7FC00003, 1'b1}, // R3
    {32'h7F800005, 32'hFFC00002, 2'd1, 1'b0, 32'h7FC00005, 1'b1}, // R3
    {32'h7F800005, 32'hFFC00002, 2'd2, 1'b0, 32'hFFC00002, 1'b1}, // R4 quiet b
    {32'h7FC00001, 32'h7F800003, 2'd2, 1'b0, 32'h7FC00001, 1'b1}, // R4 quiet a
    {32'h7F800005, 32'h7F800003, 2'd2, 1'b0, 32'h7FC00005, 1'b1}, // R4 sig pair
    {32'h7FC00001, 32'hFFC00002, 2'd2, 1'b0, 32'hFFC00002, 1'b0}, // R4 quiet pair
    {32'hFFC00007, 32'h7FC00007, 2'd2, 1'b0, 32'h7FC00007, 1'b0}, // R5 tie b+
    {32'h7FC00007, 32'hFFC00007, 2'd2, 1'b0, 32'h7FC00007, 1'b0}, // R5 tie a+
    {32'h7F800005, 32'h3F800000, 2'd2, 1'b0, 32'h7FC00005, 1'b1}, // R4 a only
    {32'h3F800000, 32'hFFC00002, 2'd2, 1'b0, 32'hFFC00002, 1'b0}, // R4 b only
    {32'hFFC00002, 32'h7F800005, 2'd3, 1'b0, 32'hFFC00002, 1'b1}, // R3 code 3
    {32'h7F800005, 32'hFFC00002, 2'd2, 1'b1, 32'h7FC00000, 1'b1}, // R7
    {32'h7FC00001, 32'hFFC00002, 2'd0, 1'b1, 32'h7FC00000, 1'b0}, // R7
    {32'hFF800009, 32'h3F800000, 2'd0, 1'b0, 32'hFFC00009, 1'b1}  // R1 sign kept
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] pol, input logic dm);
    @(negedge clk_i);
    valid_i = 1'b1; a_i = a; b_i = b; policy_i = pol; dflt_mode_i = dm;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > WDOG && !done) begin
        done = 1'b1;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WDOG);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] held;
    logic        held_inv;
    repeat (3) @(negedge clk_i);
    check("R10 valid", {31'd0, valid_o}, 32'd0);
    check("R10 result", result_o, 32'd0);
    check("R10 invalid", {31'd0, invalid_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][99:68], VEC[i][67:36], VEC[i][35:34], VEC[i][33]);
      check($sformatf("R8 valid v%0d", i), {31'd0, valid_o}, 32'd1);
      check($sformatf("R1-4/R5/R7 result v%0d", i), result_o, VEC[i][32:1]);
      check($sformatf("R6 invalid v%0d", i), {31'd0, invalid_o}, {31'd0, VEC[i][0]});
    end

    // R9: inputs change with valid_i low, outputs must hold
    held = result_o; held_inv = invalid_o;
    @(negedge clk_i);
    a_i = 32'h7F800001; b_i = 32'h7F800002; policy_i = 2'd0; dflt_mode_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R9 hold result", result_o, held);
    check("R9 hold invalid", {31'd0, invalid_o}, {31'd0, held_inv});
    check("R8 valid low", {31'd0, valid_o}, 32'd0);

    // R8: back-to-back strobes
    @(negedge clk_i);
    valid_i = 1'b1; a_i = 32'h7FC00011; b_i = 32'h3F800000; policy_i = 2'd1; dflt_mode_i = 1'b0;
    @(negedge clk_i);
    check("R8 b2b first", result_o, 32'h7FC00011);
    a_i = 32'h3F800000; b_i = 32'h7F800022; policy_i = 2'd0;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R8 b2b second", result_o, 32'h7FC00022);
    check("R6 b2b invalid", {31'd0, invalid_o}, 32'd1);

    // R10: asynchronous reset mid-run
    rst_ni = 1'b0;
    #1;
    check("R10 async reset", result_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule